// File: doc/BRIEF.md
# Brushless Motor Commutation Sequencer

This block converts the three digital rotor-position sensor lines of a three-phase brushless fan motor into six gate enables, one high-side and one low-side enable per bridge phase. Every valid sensor code selects exactly one phase to source current and one phase to sink it. The rotation sense is chosen by a direction input. The reverse table is the forward table addressed by the bitwise complement of the sensor code.

A stop input and an over-temperature fault remove all drive. An undervoltage fault and the PWM chopping input act only on the low-side switches, so the high-side switch of the active step stays on for the whole step. Both faults are latched with hysteresis. A trip comparator input sets each fault, and a separate release comparator input clears it. A direction request does not reach the lookup at once. It stays pending until the drive has been off for a parameterised number of consecutive clock cycles. Drive counts as off when the block is stopped, the PWM input is low, or a fault is latched. This keeps the bridge from conducting through during a reversal.

Top module: `bldc_commutator`

## Requirements
- R1: With the forward direction applied, the sensor code {hall_i[2],hall_i[1],hall_i[0]} selects source→sink as follows: 101 phase2→phase1, 100 phase3→phase1, 110 phase3→phase2, 010 phase1→phase2, 011 phase1→phase3, 001 phase2→phase3. Phase n is bit n-1 of hs_en_o (source) and of ls_en_o (sink).
- R2: With the reverse direction applied, the same source→sink pairs are selected by the bitwise complement of the forward codes (for example 010 gives phase2→phase1 and 110 gives phase2→phase3).
- R3: Sensor codes 000 and 111 turn all six enables off, in either direction.
- R4: While stop_i is high, all six enables are off.
- R5: While pwm_on_i is low, all low-side enables are off and the high-side enable of the current step stays on.
- R6: An undervoltage trip turns all low-side enables off and leaves the high-side enables unaffected. The fault stays latched until uv_release_i is high while uv_trip_i is low, and trip wins when both are high.
- R7: An over-temperature trip turns all six enables off. The fault stays latched until ot_release_i is high while ot_trip_i is low.
- R8: A change of dir_rev_i (1 = reverse, 0 = forward) is applied only after DEAD_CYCLES consecutive clock cycles in which the request differs from the applied direction and drive is off. Drive is off when stopped, when the PWM input is low, or when a fault is latched. A request made while driving has no effect on the outputs.
- R9: When the request returns to the applied direction before the window completes, the window count restarts from zero.
- R10: Enables are registered. They change one clock edge after the input that causes them. No phase ever has its high-side and low-side enables on together, and at most one phase is enabled on each side.
- R11: Reset (synchronous, active high) turns all enables off, applies the reverse direction, and leaves the undervoltage fault latched until its release input is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_i | input | 3 | Sensor code; bit 2 is the first sensor, bit 0 the third |
| dir_rev_i | input | 1 | Requested direction: 1 reverse, 0 forward |
| stop_i | input | 1 | 1 stops the motor, 0 runs it |
| pwm_on_i | input | 1 | Low-side chopping: 1 allows conduction |
| uv_trip_i | input | 1 | Supply is below the undervoltage trip level |
| uv_release_i | input | 1 | Supply is above the undervoltage release level |
| ot_trip_i | input | 1 | Temperature is above the shutdown level |
| ot_release_i | input | 1 | Temperature is below the restart level |
| hs_en_o | output | 3 | High-side (source) enables, bit n-1 = phase n |
| ls_en_o | output | 3 | Low-side (sink) enables, bit n-1 = phase n |

## Verification
The bench walks both commutation tables, including the two illegal codes. A swapped direction or a wrong complement would put current into the wrong phase pair. It chops and trips each fault, then checks that the high side survives PWM and undervoltage, and that both faults hold through the gap between their trip and release levels. A plain comparator in place of the latch would let drive back on too early. The reversal window is probed one cycle short of DEAD_CYCLES, exactly at it, and with a cancelled request in the middle. A design that switched direction early, or kept its count across a cancel, would reverse the motor while it is still conducting.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

  localparam int NPH = 3;

  typedef logic [NPH-1:0] phase_mask_t;

  // One commutation step: which phase sources and which sinks
  typedef struct packed {
    phase_mask_t src;
    phase_mask_t snk;
  } comm_step_t;

  localparam phase_mask_t PH1 = 3'b001;
  localparam phase_mask_t PH2 = 3'b010;
  localparam phase_mask_t PH3 = 3'b100;

endpackage

// File: rtl/bldc_hall_decoder.sv
module bldc_hall_decoder
  import bldc_comm_pkg::*;
(
  input  logic [2:0] hall_i,
  input  logic       rev_i,
  output comm_step_t step_o
);

  logic [2:0] code;

  // Reverse uses the forward table at the complemented code
  assign code = hall_i ^ {3{rev_i}};

  always_comb begin
    step_o = '0;
    unique case (code)
      3'b101: begin step_o.src = PH2; step_o.snk = PH1; end
      3'b100: begin step_o.src = PH3; step_o.snk = PH1; end
      3'b110: begin step_o.src = PH3; step_o.snk = PH2; end
      3'b010: begin step_o.src = PH1; step_o.snk = PH2; end
      3'b011: begin step_o.src = PH1; step_o.snk = PH3; end
      3'b001: begin step_o.src = PH2; step_o.snk = PH3; end
      default: step_o = '0;   // 000 and 111 are illegal
    endcase
  end

endmodule

// File: rtl/bldc_fault_latch.sv
module bldc_fault_latch #(
  parameter bit SET_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic release_i,
  output logic flag_next_o,
  output logic flag_q_o
);

  // Trip dominates; release only clears when trip is not active
  always_comb begin
    if (trip_i)         flag_next_o = 1'b1;
    else if (release_i) flag_next_o = 1'b0;
    else                flag_next_o = flag_q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q_o <= SET_AT_RESET;
    else     flag_q_o <= flag_next_o;
  end

endmodule

// File: rtl/bldc_dir_interlock.sv
module bldc_dir_interlock #(
  parameter int DEAD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req_rev_i,
  input  logic drive_off_i,
  output logic dir_rev_o
);

  localparam int CW = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYCLES - 1);

  logic          pending;
  logic [CW-1:0] cnt_q;

  assign pending = (req_rev_i != dir_rev_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rev_o <= 1'b1;
      cnt_q     <= '0;
    end else if (!pending || !drive_off_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      dir_rev_o <= req_rev_i;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bldc_gate_stage.sv
module bldc_gate_stage
  import bldc_comm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  comm_step_t  step_i,
  input  logic        hs_allow_i,
  input  logic        ls_allow_i,
  output phase_mask_t hs_en_o,
  output phase_mask_t ls_en_o
);

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) begin
        hs_en_o[p] <= 1'b0;
        ls_en_o[p] <= 1'b0;
      end else begin
        hs_en_o[p] <= step_i.src[p] & hs_allow_i;
        // a phase that sources never sinks in the same step
        ls_en_o[p] <= step_i.snk[p] & ~step_i.src[p] & ls_allow_i;
      end
    end
  end

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_comm_pkg::*;
#(
  parameter int DEAD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] hall_i,
  input  logic       dir_rev_i,
  input  logic       stop_i,
  input  logic       pwm_on_i,
  input  logic       uv_trip_i,
  input  logic       uv_release_i,
  input  logic       ot_trip_i,
  input  logic       ot_release_i,
  output logic [2:0] hs_en_o,
  output logic [2:0] ls_en_o
);

  logic       uv_next, uv_q;
  logic       ot_next, ot_q;
  logic       dir_rev_q;
  logic       drive_off;
  logic       hs_allow, ls_allow;
  comm_step_t step;

  bldc_fault_latch #(.SET_AT_RESET(1'b1)) u_uv (
    .clk(clk), .rst(rst), .trip_i(uv_trip_i), .release_i(uv_release_i),
    .flag_next_o(uv_next), .flag_q_o(uv_q)
  );

  bldc_fault_latch #(.SET_AT_RESET(1'b0)) u_ot (
    .clk(clk), .rst(rst), .trip_i(ot_trip_i), .release_i(ot_release_i),
    .flag_next_o(ot_next), .flag_q_o(ot_q)
  );

  assign drive_off = stop_i | ~pwm_on_i | uv_next | ot_next;

  bldc_dir_interlock #(.DEAD_CYCLES(DEAD_CYCLES)) u_dir (
    .clk(clk), .rst(rst), .req_rev_i(dir_rev_i),
    .drive_off_i(drive_off), .dir_rev_o(dir_rev_q)
  );

  bldc_hall_decoder u_dec (
    .hall_i(hall_i), .rev_i(dir_rev_q), .step_o(step)
  );

  assign hs_allow = ~stop_i & ~ot_next;
  assign ls_allow = hs_allow & pwm_on_i & ~uv_next;

  bldc_gate_stage u_gate (
    .clk(clk), .rst(rst), .step_i(step),
    .hs_allow_i(hs_allow), .ls_allow_i(ls_allow),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );

endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] hall_i,
  input logic       stop_i,
  input logic       pwm_on_i,
  input logic       uv_trip_i,
  input logic       ot_trip_i,
  input logic       dir_rev_q,
  input logic       drive_off,
  input logic [2:0] hs_en_o,
  input logic [2:0] ls_en_o
);

  assert_phase_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    (hs_en_o & ls_en_o) == 3'b000);

  assert_side_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hs_en_o) && $onehot0(ls_en_o));

  assert_illegal_code_off_R3: assert property (@(posedge clk) disable iff (rst)
    (hall_i == 3'b000 || hall_i == 3'b111) |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

  assert_stop_off_R4: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

  assert_pwm_low_side_R5: assert property (@(posedge clk) disable iff (rst)
    !pwm_on_i |=> ls_en_o == 3'b000);

  assert_uv_low_side_R6: assert property (@(posedge clk) disable iff (rst)
    uv_trip_i |=> ls_en_o == 3'b000);

  assert_ot_all_off_R7: assert property (@(posedge clk) disable iff (rst)
    ot_trip_i |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

  assert_dir_in_off_window_R8: assert property (@(posedge clk) disable iff (rst)
    (dir_rev_q != $past(dir_rev_q)) |-> $past(drive_off));

endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
  .clk(clk), .rst(rst), .hall_i(hall_i), .stop_i(stop_i),
  .pwm_on_i(pwm_on_i), .uv_trip_i(uv_trip_i), .ot_trip_i(ot_trip_i),
  .dir_rev_q(dir_rev_q), .drive_off(drive_off),
  .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
);

// File: tb/bldc_commutator_test.sv
`timescale 1ns/1ps
module bldc_commutator_test;

  localparam int DEAD = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall = 3'b010;
  logic       rev = 1'b1;
  logic       stop = 1'b0;
  logic       pwm = 1'b1;
  logic       uvt = 1'b0, uvr = 1'b0, ott = 1'b0, otr = 1'b1;
  logic [2:0] hs, ls;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bldc_commutator #(.DEAD_CYCLES(DEAD)) uut (
    .clk(clk), .rst(rst), .hall_i(hall), .dir_rev_i(rev), .stop_i(stop),
    .pwm_on_i(pwm), .uv_trip_i(uvt), .uv_release_i(uvr),
    .ot_trip_i(ott), .ot_release_i(otr), .hs_en_o(hs), .ls_en_o(ls)
  );

  // {rev, hall, expected hs, expected ls}
  localparam logic [9:0] VEC [16] = '{
    10'b1_010_010_001, 10'b1_011_100_001, 10'b1_001_100_010, 10'b1_101_001_010,
    10'b1_100_001_100, 10'b1_110_010_100, 10'b1_000_000_000, 10'b1_111_000_000,
    10'b0_101_010_001, 10'b0_100_100_001, 10'b0_110_100_010, 10'b0_010_001_010,
    10'b0_011_001_100, 10'b0_001_010_100, 10'b0_000_000_000, 10'b0_111_000_000
  };

  task automatic check(string req, logic [2:0] ehs, logic [2:0] els);
    checks++;
    if (hs !== ehs || ls !== els) begin
      errors++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", req, hs, ls, ehs, els);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic tickn(int n);
    repeat (n) tick();
  endtask

  task automatic set_dir(logic r);
    stop = 1'b1;
    rev  = r;
    tickn(DEAD);
    stop = 1'b0;
  endtask

  initial begin
    logic cur_rev;
    // R11: reset state with running inputs applied
    tickn(3);
    check("R11 reset outputs off", 3'b000, 3'b000);
    rst = 1'b0;
    tick();
    check("R11 reverse applied, undervoltage latched", 3'b010, 3'b000);
    uvr = 1'b1;
    tick();
    check("R11 release clears undervoltage", 3'b010, 3'b001);
    cur_rev = 1'b1;

    for (int i = 0; i < 16; i++) begin
      logic [9:0] v;
      string tag;
      v = VEC[i];
      if (v[9] != cur_rev) begin
        set_dir(v[9]);
        cur_rev = v[9];
      end
      hall = v[8:6];
      tick();
      if (v[8:6] == 3'b000 || v[8:6] == 3'b111) tag = "R3 illegal code";
      else if (v[9]) tag = "R2 reverse table";
      else tag = "R1 forward table";
      check(tag, v[5:3], v[2:0]);
    end

    // now forward; R10 latency
    hall = 3'b101;
    tick();
    hall = 3'b011;
    #1;
    check("R10 no change before edge", 3'b010, 3'b001);
    tick();
    check("R10 change after one edge", 3'b001, 3'b100);
    hall = 3'b101;
    tick();

    // R5
    pwm = 1'b0;
    tick();
    check("R5 pwm low keeps high side", 3'b010, 3'b000);
    pwm = 1'b1;
    tick();
    check("R5 pwm high restores", 3'b010, 3'b001);

    // R4
    stop = 1'b1;
    tick();
    check("R4 stop all off", 3'b000, 3'b000);
    stop = 1'b0;
    tick();

    // R6
    uvt = 1'b1;
    tick();
    check("R6 trip wins over release", 3'b010, 3'b000);
    uvt = 1'b0; uvr = 1'b0;
    tick();
    check("R6 fault held in hysteresis band", 3'b010, 3'b000);
    uvr = 1'b1;
    tick();
    check("R6 release restores low side", 3'b010, 3'b001);

    // R7
    ott = 1'b1;
    tick();
    check("R7 thermal trip all off", 3'b000, 3'b000);
    ott = 1'b0; otr = 1'b0;
    tick();
    check("R7 fault held in hysteresis band", 3'b000, 3'b000);
    otr = 1'b1;
    tick();
    check("R7 release restores drive", 3'b010, 3'b001);

    // R8
    rev = 1'b1;
    tickn(8);
    check("R8 request ignored while driving", 3'b010, 3'b001);
    stop = 1'b1;
    tickn(DEAD - 1);
    stop = 1'b0;
    tick();
    check("R8 window one cycle short", 3'b010, 3'b001);
    stop = 1'b1;
    tickn(DEAD);
    stop = 1'b0;
    tick();
    check("R8 applied after full stop window", 3'b001, 3'b010);
    pwm = 1'b0;
    rev = 1'b0;
    tickn(DEAD);
    pwm = 1'b1;
    tick();
    check("R8 applied after zero-duty window", 3'b010, 3'b001);

    // R9
    pwm = 1'b0;
    rev = 1'b1;
    tickn(DEAD - 1);
    rev = 1'b0;
    tick();
    rev = 1'b1;
    tickn(DEAD - 1);
    pwm = 1'b1;
    tick();
    check("R9 cancel restarts window", 3'b010, 3'b001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule